// File: doc/BRIEF.md
# External Interrupt Pin Sensing Unit

This unit monitors four external interrupt pins and turns activity on them into sticky interrupt flags. Each pin has its own sense selection, built from a mode bit and a polarity bit. The choices are active-high level, active-low level, rising edge and falling edge. Every pin passes through a two-flop synchroniser before detection, so the pins may change at any time relative to the clock.

A flag stays set until software writes a 1 to its bit in the flag register. In level mode, a flag that is cleared while its level is still asserted sets again at once. Each flag drives its own interrupt request output. A single wakeup output rises when any set flag belongs to a pin whose wake-enable bit is 1, so the pin can bring the system out of power-down.

Software reaches the unit through a plain register interface with four 8-bit registers. The interface has no back-pressure. A write completes on the clock edge on which `wr_en` is high, and read data is a combinational function of `addr`.

Top module: `extint_sense`

## Requirements
- R1: After reset, the wake-enable, mode and polarity registers read 0, which makes every pin low-level sensitive. With all pins held high, all flags, `irq_o` and `wake_o` are 0.
- R2: When mode bit i is 0, flag i sets while synchronised pin i is at the active level. Polarity bit i = 1 means high is active, and 0 means low is active. A clear write made while that level persists leaves the flag set.
- R3: When mode bit i is 1 and polarity bit i is 1, a 0-to-1 transition of pin i sets flag i. A pin held high, or a 1-to-0 transition, sets nothing.
- R4: When mode bit i is 1 and polarity bit i is 0, a 1-to-0 transition of pin i sets flag i. A 0-to-1 transition sets nothing.
- R5: A write to the flag register clears each flag whose data bit (bit i for pin i) is 1 and leaves the flags whose data bit is 0 unchanged.
- R6: When a set event and a clear write for the same pin fall on the same clock edge, the flag ends up set.
- R7: `irq_o[i]` equals flag bit i, as read back from the flag register.
- R8: `wake_o` is 1 exactly when some pin i has both its flag and its wake-enable bit at 1. A pin whose wake-enable bit is 0 never raises `wake_o`.
- R9: A change to a pin's mode or polarity that makes the pin's present state active sets that pin's flag. The flag then stays set until a clear write removes it.
- R10: Writes to bits 7:4 of any register are ignored, and those bits read as 0. Addresses outside the map read 0 and ignore writes.
- R11: Register map (4-bit address): flags at 0x0, wake enable at 0x4, mode at 0x8, polarity at 0xC. Bit i of each register belongs to pin i.
- R12: A pin change driven after one rising clock edge shows on `irq_o` after the third rising edge that follows, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_o | output | 4 | Per-pin interrupt requests, one per flag |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions assume three things about the inputs. The pins are held high (inactive) while reset is asserted, which matches the synchroniser's reset value. `wr_en`, `addr` and `wr_data` are defined and stable around each rising edge. The bench meets these conditions because it keeps every pin high during reset and changes all inputs only on falling clock edges. The bench also places clear writes and pin changes on chosen edges, so that the same-edge set-and-clear case and the synchroniser latency are each exercised on purpose.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned PIN_COUNT  = 4;
  localparam int unsigned REG_WIDTH  = 8;
  localparam int unsigned ADDR_WIDTH = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  // register offsets within the word-addressed space
  localparam logic [ADDR_WIDTH-1:0] OFF_FLAG = 4'h0;
  localparam logic [ADDR_WIDTH-1:0] OFF_WAKE = 4'h4;
  localparam logic [ADDR_WIDTH-1:0] OFF_MODE = 4'h8;
  localparam logic [ADDR_WIDTH-1:0] OFF_POL  = 4'hC;

  // {mode, polarity} selects the sensing kind
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to ones: the idle (inactive) pin level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic evt_o,
  output logic flag_o
);
  logic   prev_q;
  logic   flag_q;
  sense_e sense;

  assign sense = sense_e'({mode_i, pol_i});

  always_comb begin
    unique case (sense)
      SENSE_LOW:  evt_o = ~level_i;
      SENSE_HIGH: evt_o = level_i;
      SENSE_FALL: evt_o = prev_q & ~level_i;
      default:    evt_o = ~prev_q & level_i;
    endcase
  end

  // a set event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      flag_q <= evt_o | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int unsigned NPINS  = PIN_COUNT,
  parameter int unsigned REG_W  = REG_WIDTH,
  parameter int unsigned ADDR_W = ADDR_WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NPINS-1:0]  flags_i,
  output logic [NPINS-1:0]  wake_en_o,
  output logic [NPINS-1:0]  mode_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [REG_W-1:0]  rd_data
);
  logic [NPINS-1:0] wake_q, mode_q, pol_q;
  logic [NPINS-1:0] wdata_lo;
  logic             unused_rsv;

  assign wdata_lo   = wr_data[NPINS-1:0];
  assign unused_rsv = ^wr_data[REG_W-1:NPINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      if (addr == OFF_WAKE) wake_q <= wdata_lo;
      if (addr == OFF_MODE) mode_q <= wdata_lo;
      if (addr == OFF_POL)  pol_q  <= wdata_lo;
    end
  end

  assign clr_o = (wr_en && addr == OFF_FLAG) ? wdata_lo : '0;

  always_comb begin
    unique case (addr)
      OFF_FLAG: rd_data = REG_W'(flags_i);
      OFF_WAKE: rd_data = REG_W'(wake_q);
      OFF_MODE: rd_data = REG_W'(mode_q);
      OFF_POL:  rd_data = REG_W'(pol_q);
      default:  rd_data = '0;
    endcase
  end

  assign wake_en_o = wake_q;
  assign mode_o    = mode_q;
  assign pol_o     = pol_q;
endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int unsigned NPINS  = PIN_COUNT,
  parameter int unsigned REG_W  = REG_WIDTH,
  parameter int unsigned ADDR_W = ADDR_WIDTH,
  parameter int unsigned SYNC_N = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [NPINS-1:0]  irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] flags_w, evt_w, clr_w;
  logic [NPINS-1:0] wake_en_w, mode_w, pol_w;

  extint_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  extint_regs #(.NPINS(NPINS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .flags_i(flags_w), .wake_en_o(wake_en_w), .mode_o(mode_w), .pol_o(pol_w),
    .clr_o(clr_w), .rd_data(rd_data)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    extint_detect u_det (
      .clk(clk), .rst_n(rst_n), .level_i(pin_sync[g]), .mode_i(mode_w[g]),
      .pol_i(pol_w[g]), .clr_i(clr_w[g]), .evt_o(evt_w[g]), .flag_o(flags_w[g])
    );
  end

  assign irq_o  = flags_w;
  assign wake_o = |(flags_w & wake_en_w);
endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk
  import extint_pkg::*;
#(
  parameter int unsigned NPINS  = PIN_COUNT,
  parameter int unsigned REG_W  = REG_WIDTH,
  parameter int unsigned ADDR_W = ADDR_WIDTH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic [NPINS-1:0]  irq_o,
  input logic              wake_o,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  wake_en,
  input logic [NPINS-1:0]  mode
);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((irq_o & $past(evt)) == $past(evt)));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_FLAG) |=> ((irq_o & $past(wr_data[NPINS-1:0] & ~evt)) == '0));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(irq_o) & ~$past(evt)) == '0);

  // R8
  wake_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en == '0) |-> !wake_o);

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:NPINS] == '0);

  // R11
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MODE) |=> (mode == $past(wr_data[NPINS-1:0])));
endmodule

bind extint_sense extint_sense_chk #(.NPINS(NPINS), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o), .evt(evt_w),
  .wake_en(wake_en_w), .mode(mode_w)
);

// File: tb/extint_sense_test.sv
`timescale 1ns/1ps
module extint_sense_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'hF;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] irq_o;
  logic       wake_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_FLAG = 4'h0, A_WAKE = 4'h4, A_MODE = 4'h8, A_POL = 4'hC;

  always #2.5 clk = ~clk;

  extint_sense uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rd_data;
  endtask

  task automatic set_pin(input int idx, input logic val);
    @(negedge clk); pins[idx] = val;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    reg_read(A_WAKE, v); check("R1", "wake reg", v, 8'h00);
    reg_read(A_MODE, v); check("R1", "mode reg", v, 8'h00);
    reg_read(A_POL,  v); check("R1", "pol reg",  v, 8'h00);
    reg_read(A_FLAG, v); check("R1", "flag reg", v, 8'h00);
    check("R1", "irq", {4'h0, irq_o}, 8'h00);
    check("R1", "wake", {7'h0, wake_o}, 8'h00);
  endtask

  task automatic test_regmap();
    logic [7:0] v;
    reg_write(A_WAKE, 8'hF0);
    reg_read(A_WAKE, v); check("R10", "reserved wake bits", v, 8'h00);
    reg_write(A_MODE, 8'hA5);
    reg_read(A_MODE, v); check("R11", "mode bits 3:0", v, 8'h05);
    reg_write(A_MODE, 8'h00);
    reg_write(4'h2, 8'hFF);
    reg_read(4'h2, v); check("R10", "unmapped read", v, 8'h00);
    reg_read(A_WAKE, v); check("R10", "unmapped write ignored", v, 8'h00);
    check("R10", "irq after config", {4'h0, irq_o}, 8'h00);
  endtask

  task automatic test_level_high();
    logic [7:0] v;
    // pin0 high; making it high-active sets the flag (R9)
    reg_write(A_POL, 8'h01);
    wait_cyc(1);
    check("R9", "spurious flag on polarity change", {4'h0, irq_o}, 8'h01);
    wait_cyc(3);
    check("R9", "spurious flag held", {4'h0, irq_o}, 8'h01);
    set_pin(0, 1'b0);
    wait_cyc(3);
    reg_write(A_FLAG, 8'h01);
    check("R5", "flag cleared", {4'h0, irq_o}, 8'h00);
    // latency through the synchroniser (R12)
    set_pin(0, 1'b1);
    wait_cyc(2);
    check("R12", "no flag after two edges", {4'h0, irq_o}, 8'h00);
    wait_cyc(1);
    check("R12", "flag after third edge", {4'h0, irq_o}, 8'h01);
    reg_write(A_FLAG, 8'h01);
    wait_cyc(1);
    check("R2", "level flag survives clear", {4'h0, irq_o}, 8'h01);
    reg_read(A_FLAG, v);
    check("R7", "irq matches flag reg", v, {4'h0, irq_o});
    reg_write(A_POL, 8'h00);
    reg_write(A_FLAG, 8'h01);
    wait_cyc(1);
    check("R5", "flag cleared after restore", {4'h0, irq_o}, 8'h00);
  endtask

  task automatic test_level_low();
    set_pin(1, 1'b0);
    wait_cyc(4);
    check("R2", "low level pin1 only", {4'h0, irq_o}, 8'h02);
    set_pin(1, 1'b1);
    wait_cyc(3);
    reg_write(A_FLAG, 8'h0D);
    check("R5", "zero data bit keeps flag", {4'h0, irq_o}, 8'h02);
    reg_write(A_FLAG, 8'h02);
    check("R5", "pin1 cleared", {4'h0, irq_o}, 8'h00);
  endtask

  task automatic test_rising();
    reg_write(A_MODE, 8'h04);
    reg_write(A_POL, 8'h04);
    set_pin(2, 1'b0);
    wait_cyc(4);
    check("R3", "falling ignored in rising mode", {4'h0, irq_o}, 8'h00);
    set_pin(2, 1'b1);
    wait_cyc(4);
    check("R3", "rising edge sets", {4'h0, irq_o}, 8'h04);
    reg_write(A_FLAG, 8'h04);
    wait_cyc(3);
    check("R3", "held high does not re-set", {4'h0, irq_o}, 8'h00);
  endtask

  task automatic test_falling();
    reg_write(A_MODE, 8'h0C);
    set_pin(3, 1'b0);
    wait_cyc(4);
    check("R4", "falling edge sets", {4'h0, irq_o}, 8'h08);
    reg_write(A_FLAG, 8'h08);
    set_pin(3, 1'b1);
    wait_cyc(4);
    check("R4", "rising ignored in falling mode", {4'h0, irq_o}, 8'h00);
  endtask

  task automatic test_set_wins();
    set_pin(3, 1'b0);
    @(negedge clk);
    reg_write(A_FLAG, 8'h08);
    check("R6", "set and clear same edge", {4'h0, irq_o}, 8'h08);
    reg_write(A_FLAG, 8'h08);
    check("R6", "later clear works", {4'h0, irq_o}, 8'h00);
    set_pin(3, 1'b1);
    wait_cyc(3);
  endtask

  task automatic test_wake();
    set_pin(1, 1'b0);
    wait_cyc(4);
    check("R8", "flag without wake enable", {6'h0, wake_o, irq_o[1]}, 8'h01);
    reg_write(A_WAKE, 8'h02);
    check("R8", "wake with enable", {7'h0, wake_o}, 8'h01);
    set_pin(1, 1'b1);
    wait_cyc(3);
    reg_write(A_FLAG, 8'h02);
    check("R8", "wake drops with flag", {7'h0, wake_o}, 8'h00);
    reg_write(A_WAKE, 8'h01);
    wait_cyc(2);
    check("R8", "enabled quiet pin no wake", {7'h0, wake_o}, 8'h00);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    test_reset();
    test_regmap();
    test_level_high();
    test_level_low();
    test_rising();
    test_falling();
    test_set_wins();
    test_wake();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule